// File: doc/BRIEF.md
# Fuse Word Programming Sequencer

This block burns one data word into a fuse array that can only be programmed one bit at a time. A start request carries a word address, the data to program and a packed timing word. The sequencer first reads the addressed fuse word. It clears every data bit whose fuse is already blown. It then walks through the word from bit 0 upward, shifting its internal data register right with zero fill, and raises the program strobe only for bits that are still 1.

The timing word sets every phase length in clock cycles. The program strobe width is in bits [11:0], the relax count in bits [15:12] and the read strobe width in bits [21:16]. The relax count lengthens every gap phase but neither strobe. A zero relax value is accepted. Once the last bit is done, the sequencer holds busy for a 2 µs quiet postamble, converted to cycles from the clock frequency parameter. It then pulses done.

Top module: `fuse_prog_seq`

## Requirements
- R1: After reset, busy_o, done_o, fuse_prog_o and fuse_rd_o are all low.
- R2: A start seen while idle first raises fuse_rd_o for max(T[21:16],1) cycles at the requested address. T is the timing word given with the start.
- R3: The data is masked with the inverse of the fuse word read back. No bit that was already 1 is strobed, and afterwards the fuse word equals old OR data.
- R4: Bits are programmed in ascending index order (bit 0 first, fuse_bit_o counting up), each at most once. This follows from a right shift with zero fill.
- R5: Each bit that is 1 after masking gets one program strobe lasting max(T[11:0],1) cycles. A bit that is 0 gets no strobe, but its slot lasts just as long.
- R6: Every non-strobe phase, whether before the read or before each bit, lasts 1+T[15:12] cycles, and a relax value of 0 is allowed. Busy therefore lasts exactly (1+R)+Sr+32*(1+R+Sp)+P cycles. R is the relax count, Sr and Sp are the read and program strobe widths from R2 and R5, and P is the postamble from R7.
- R7: After the last bit slot, busy stays high with no strobe for P = 2*CLK_MHZ cycles (2 µs).
- R8: done_o is high for exactly one cycle: the first cycle in which busy_o is low again.
- R9: A start while busy is ignored. Address, data and timing are captured at the accepted start, so later changes on those inputs have no effect on the word being programmed or on any other word.
- R10: fuse_rd_o and fuse_prog_o are never high together, and neither is high while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, accepted only while idle |
| addr_i | input | ADDR_W | Fuse word address |
| data_i | input | WORD_W | Bits to program (1 = burn) |
| timing_i | input | 22 | Timing word: [11:0] program width, [15:12] relax, [21:16] read width |
| fuse_rdata_i | input | WORD_W | Fuse word at fuse_addr_o |
| fuse_addr_o | output | ADDR_W | Latched word address presented to the array |
| fuse_bit_o | output | log2(WORD_W) | Index of the bit in its program slot |
| fuse_prog_o | output | 1 | Program strobe for bit fuse_bit_o |
| fuse_rd_o | output | 1 | Read strobe for the addressed word |
| busy_o | output | 1 | Operation in progress, including the postamble |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume that the fuse array model returns the addressed word combinationally and that a bit only becomes 1 after a strobe that lasts at least one clock edge. This is why a bit still reads 0 in the first cycle of its program strobe. The bench model obeys this: it sets a bit at the clock edge that ends a strobe cycle and changes nothing else. Random timing fields are kept small so each operation stays short. Start pulses that arrive mid-operation, and the random address, data and timing values driven after acceptance, exercise the capture rule without ever overlapping a completion.

// File: rtl/fps_pkg.sv
package fps_pkg;
  localparam int TIM_W = 22;

  // packed timing word: read width [21:16], relax [15:12], program width [11:0]
  typedef struct packed {
    logic [5:0]  rd_w;
    logic [3:0]  relax;
    logic [11:0] prog_w;
  } fps_timing_t;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RD_GAP,
    S_RD_STB,
    S_BIT_GAP,
    S_BIT_STB,
    S_POST
  } fps_state_e;
endpackage

// File: rtl/fps_phase_timer.sv
module fps_phase_timer #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] val_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             cnt_en;

  always_comb begin
    cnt_en = load_i || (cnt_q != '0);
    cnt_n  = load_i ? val_i : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_n;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/fps_shifter.sv
module fps_shifter #(
  parameter int WORD_W = 32,
  localparam int IDX_W = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [WORD_W-1:0] load_val_i,
  input  logic              shift_i,
  output logic              lsb_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic              last_o
);
  logic [WORD_W-1:0] sh_q, sh_n;
  logic [IDX_W-1:0]  idx_q, idx_n;
  logic              en;

  assign last_o = (idx_q == IDX_W'(WORD_W - 1));

  always_comb begin
    en    = load_i || shift_i;
    sh_n  = sh_q;
    idx_n = idx_q;
    if (load_i) begin
      sh_n  = load_val_i;
      idx_n = '0;
    end else if (shift_i) begin
      sh_n  = {1'b0, sh_q[WORD_W-1:1]};
      idx_n = last_o ? '0 : idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      idx_q <= '0;
    end else if (en) begin
      sh_q  <= sh_n;
      idx_q <= idx_n;
    end
  end

  assign lsb_o = sh_q[0];
  assign idx_o = idx_q;

  // R4: zero fill - once the final slot shifts out, nothing is left to burn
  a_r4_zero_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_i && last_o && !load_i) |=> (sh_q == '0));
endmodule

// File: rtl/fuse_prog_seq.sv
module fuse_prog_seq
  import fps_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int WORD_W  = 32,
  parameter int CLK_MHZ = 250
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start_i,
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic [WORD_W-1:0]          data_i,
  input  logic [TIM_W-1:0]           timing_i,
  input  logic [WORD_W-1:0]          fuse_rdata_i,
  output logic [ADDR_W-1:0]          fuse_addr_o,
  output logic [$clog2(WORD_W)-1:0]  fuse_bit_o,
  output logic                       fuse_prog_o,
  output logic                       fuse_rd_o,
  output logic                       busy_o,
  output logic                       done_o
);
  localparam int POST_CYC = 2 * CLK_MHZ;
  localparam int CNT_W    = (POST_CYC > 4096) ? $clog2(POST_CYC) : 12;
  localparam int IDX_W    = $clog2(WORD_W);

  fps_state_e        state_q, state_n;
  logic [ADDR_W-1:0] addr_q;
  logic [WORD_W-1:0] data_q;
  fps_timing_t       tim_q, tim_in;
  logic              done_q, done_n;
  logic              accept;

  logic              t_load, t_zero;
  logic [CNT_W-1:0]  t_val;
  logic              cap, shift, cur_bit, last_bit;
  logic [IDX_W-1:0]  idx;
  logic [CNT_W-1:0]  relax_in, relax_len, rd_len, pg_len;

  assign tim_in    = fps_timing_t'(timing_i);
  assign accept    = (state_q == S_IDLE) && start_i;
  assign relax_in  = CNT_W'(tim_in.relax);
  assign relax_len = CNT_W'(tim_q.relax);
  assign rd_len    = (tim_q.rd_w == '0)   ? '0 : CNT_W'(tim_q.rd_w - 6'd1);
  assign pg_len    = (tim_q.prog_w == '0) ? '0 : CNT_W'(tim_q.prog_w - 12'd1);

  fps_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (t_load),
    .val_i  (t_val),
    .zero_o (t_zero)
  );

  fps_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (cap),
    .load_val_i (data_q & ~fuse_rdata_i),
    .shift_i    (shift),
    .lsb_o      (cur_bit),
    .idx_o      (idx),
    .last_o     (last_bit)
  );

  // next-state logic
  always_comb begin
    state_n = state_q;
    t_load  = 1'b0;
    t_val   = '0;
    cap     = 1'b0;
    shift   = 1'b0;
    done_n  = 1'b0;
    unique case (state_q)
      S_IDLE: if (start_i) begin
        state_n = S_RD_GAP; t_load = 1'b1; t_val = relax_in;
      end
      S_RD_GAP: if (t_zero) begin
        state_n = S_RD_STB; t_load = 1'b1; t_val = rd_len;
      end
      S_RD_STB: if (t_zero) begin
        state_n = S_BIT_GAP; t_load = 1'b1; t_val = relax_len; cap = 1'b1;
      end
      S_BIT_GAP: if (t_zero) begin
        state_n = S_BIT_STB; t_load = 1'b1; t_val = pg_len;
      end
      S_BIT_STB: if (t_zero) begin
        shift  = 1'b1;
        t_load = 1'b1;
        if (last_bit) begin
          state_n = S_POST; t_val = CNT_W'(POST_CYC - 1);
        end else begin
          state_n = S_BIT_GAP; t_val = relax_len;
        end
      end
      S_POST: if (t_zero) begin
        state_n = S_IDLE; done_n = 1'b1;
      end
      default: state_n = S_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      done_q  <= done_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
      tim_q  <= '0;
    end else if (accept) begin
      addr_q <= addr_i;
      data_q <= data_i;
      tim_q  <= tim_in;
    end
  end

  assign fuse_addr_o = addr_q;
  assign fuse_bit_o  = idx;
  assign fuse_rd_o   = (state_q == S_RD_STB);
  assign fuse_prog_o = (state_q == S_BIT_STB) && cur_bit;
  assign busy_o      = (state_q != S_IDLE);
  assign done_o      = done_q;

  // R10: strobes exclusive
  a_r10_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(fuse_rd_o && fuse_prog_o));
  // R10 / R1: quiet while idle
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!fuse_rd_o && !fuse_prog_o));
  // R8: done only once busy has dropped, and only for one cycle
  a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R9: address held for the whole operation
  a_r9_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> $stable(fuse_addr_o));
  // R3: a strobe never starts on a bit that already reads blown
  a_r3_no_reburn: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fuse_prog_o) |-> !fuse_rdata_i[fuse_bit_o]);
endmodule

// File: tb/tb_fuse_prog_seq.sv
`timescale 1ns/1ps
module tb_fuse_prog_seq;
  localparam int AW = 6;
  localparam int P  = 2 * 250;  // 2 us at 250 MHz

  logic clk, rst_n, start_i;
  logic [AW-1:0] addr_i;
  logic [31:0] data_i, fuse_rdata;
  logic [21:0] timing_i;
  logic [AW-1:0] fuse_addr;
  logic [4:0] fuse_bit;
  logic fuse_prog, fuse_rd, busy, done;

  fuse_prog_seq #(.ADDR_W(AW), .WORD_W(32), .CLK_MHZ(250)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .addr_i(addr_i),
    .data_i(data_i), .timing_i(timing_i), .fuse_rdata_i(fuse_rdata),
    .fuse_addr_o(fuse_addr), .fuse_bit_o(fuse_bit), .fuse_prog_o(fuse_prog),
    .fuse_rd_o(fuse_rd), .busy_o(busy), .done_o(done));

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // behavioural fuse array
  logic [31:0] fmem [0:(1<<AW)-1];
  assign fuse_rdata = fmem[fuse_addr];
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < (1<<AW); i++) fmem[i] <= (i * 32'h9E3779B9) & 32'h0F0F_33C3;
    end else if (fuse_prog) begin
      fmem[fuse_addr][fuse_bit] <= 1'b1;
    end
  end

  // monitor (negedge), cumulative counters
  int busy_tot, rd_tot, done_tot, order_bad, addr_bad, tail, last_bit;
  int stb_tot [0:31];
  logic [AW-1:0] exp_addr;
  initial begin
    busy_tot = 0; rd_tot = 0; done_tot = 0; order_bad = 0; addr_bad = 0;
    tail = 0; last_bit = -1;
    for (int i = 0; i < 32; i++) stb_tot[i] = 0;
  end
  always @(negedge clk) if (rst_n) begin
    if (busy) busy_tot++;
    if (done) done_tot++;
    if (fuse_rd) begin rd_tot++; last_bit = -1; end
    if (fuse_prog) begin
      stb_tot[fuse_bit]++;
      if (int'(fuse_bit) < last_bit) order_bad++;
      last_bit = int'(fuse_bit);
    end
    if (busy && fuse_addr != exp_addr) addr_bad++;
    if (fuse_rd || fuse_prog) tail = 0;
    else if (busy) tail++;
  end

  int total, bad;
  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic int exp_busy(int r, int sr, int sp);
    return (1 + r) + sr + 32 * (1 + r + sp) + P;
  endfunction

  function automatic int exp_tail(logic [31:0] m, int r, int sp);
    int h;
    h = -1;
    for (int i = 0; i < 32; i++) if (m[i]) h = i;
    return (31 - h) * (1 + r + sp) + P;
  endfunction

  task automatic run_op(input logic [AW-1:0] a, input logic [31:0] d,
                        input logic [21:0] t, input bit inj);
    logic [31:0] old, other_old, m;
    int r, sr, sp, b0, r0, d0, o0, a0, guard, bitbad;
    int s0 [0:31];
    @(posedge clk);
    old = fmem[a];
    other_old = fmem[a ^ 6'd1];
    m  = d & ~old;
    r  = int'(t[15:12]);
    sr = (t[21:16] == 0) ? 1 : int'(t[21:16]);
    sp = (t[11:0] == 0) ? 1 : int'(t[11:0]);
    exp_addr = a;
    b0 = busy_tot; r0 = rd_tot; d0 = done_tot; o0 = order_bad; a0 = addr_bad;
    for (int i = 0; i < 32; i++) s0[i] = stb_tot[i];
    @(negedge clk);
    start_i = 1'b1; addr_i = a; data_i = d; timing_i = t;
    @(negedge clk);
    start_i = 1'b0; addr_i = AW'($urandom); data_i = ~d; timing_i = 22'($urandom);
    if (inj) begin
      repeat (5) @(negedge clk);
      start_i = 1'b1; addr_i = a ^ 6'd1; data_i = 32'hFFFF_FFFF;
      @(negedge clk);
      start_i = 1'b0;
      repeat (40) @(negedge clk);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    guard = 0;
    while (done_tot == d0 && guard < 100000) begin @(posedge clk); guard++; end
    @(posedge clk);
    chk(busy_tot - b0 == exp_busy(r, sr, sp), "R6 busy length", busy_tot - b0, exp_busy(r, sr, sp));
    chk(rd_tot - r0 == sr, "R2 read strobe width", rd_tot - r0, sr);
    chk(fmem[a] == (old | d), "R3 fuse word old|data", fmem[a], old | d);
    bitbad = 0;
    for (int i = 0; i < 32; i++)
      if (stb_tot[i] - s0[i] != (m[i] ? sp : 0)) bitbad++;
    chk(bitbad == 0, "R5 per-bit strobe cycles", bitbad, 0);
    chk(order_bad == o0, "R4 ascending bit order", order_bad - o0, 0);
    chk(tail == exp_tail(m, r, sp), "R7 quiet postamble", tail, exp_tail(m, r, sp));
    chk(done_tot - d0 == 1, "R8 single done pulse", done_tot - d0, 1);
    chk(addr_bad == a0, "R9 address captured", addr_bad - a0, 0);
    if (inj) chk(fmem[a ^ 6'd1] == other_old, "R9 start while busy ignored", fmem[a ^ 6'd1], other_old);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    total = 0; bad = 0;
    rst_n = 1'b0; start_i = 1'b0; addr_i = '0; data_i = '0; timing_i = '0;
    exp_addr = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk(!busy && !done && !fuse_prog && !fuse_rd, "R1 reset outputs",
        {busy, done, fuse_prog, fuse_rd}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !fuse_prog && !fuse_rd, "R1 idle after reset",
        {busy, done, fuse_prog, fuse_rd}, 0);
    // directed corner cases
    run_op(6'd0,  32'hFFFF_FFFF, {6'd3, 4'd0, 12'd2}, 1'b0); // R6 relax zero
    run_op(6'd0,  32'hFFFF_FFFF, {6'd0, 4'd2, 12'd0}, 1'b0); // R3 fully blown, zero widths
    run_op(6'd5,  32'h8000_0000, {6'd1, 4'd1, 12'd4}, 1'b0); // R7 top bit only
    run_op(6'd6,  32'h0000_0001, {6'd2, 4'd3, 12'd3}, 1'b1); // R9 start while busy
    run_op(6'd7,  32'h0000_0000, {6'd5, 4'd1, 12'd1}, 1'b0); // R5 nothing to burn
    run_op(6'd9,  32'hA5A5_5A5A, {6'd2, 4'd15, 12'd2}, 1'b0); // R6 max relax
    // random mix
    for (int k = 0; k < 24; k++)
      run_op(AW'($urandom), $urandom,
             {6'($urandom_range(0, 6)), 4'($urandom_range(0, 3)), 12'($urandom_range(0, 6))},
             1'(k % 3 == 0));
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule